// File: doc/BRIEF.md
# Burst Address Sequencer

This block produces the internal word address for a four-beat burst into a synchronous memory. An external address is captured at the start of a burst. After that the two low address bits walk through the burst while the upper bits stay fixed. The walk is linear when the order strap is low: the start value counts upward modulo four. It is interleaved when the strap is high: each beat is the start value XORed with the beat number.

A burst can be opened by either of two address-status strobes. The processor strobe is masked by the active-low primary chip enable. The controller strobe is not masked, so it can start a cycle or turn the block off even while the primary enable is high. The two secondary enables, one active high and one active low, are only looked at when a strobe is active. Between strobes, the advance input steps to the next beat or, when high, holds the current address so that a burst can be suspended.

The block also qualifies the write request so that a consumer knows when a write may be performed. The first cycle after a processor-strobe start is always a read.

Top module: `burst_addr_seq`

## Requirements
- R1: After reset `curAddr` is zero, and `selected`, `procFirst`, `deselPulse` and `writeEff` are all low.
- R2: When a strobe is active and the chip is fully enabled (`selN` low, `selHi` high, `selLoN` low), the next cycle shows `curAddr` equal to `extAddr`, `selected` high and the beat number at zero. A strobe is active when `ctrlStrobeN` is low, or when `procStrobeN` is low while `selN` is low.
- R3: A low `procStrobeN` while `selN` is high is ignored: nothing is loaded, there is no deselect, and the cycle behaves as a cycle with no strobe.
- R4: A low `ctrlStrobeN` while `selN` is high deselects the block: `selected` falls, `deselPulse` is high for that cycle, and `curAddr` keeps its value.
- R5: An active strobe with `selHi` low or `selLoN` high also deselects the block, the same way as R4.
- R6: In a cycle with no active strobe, `selHi` and `selLoN` have no effect: `selected` is held and `deselPulse` is low.
- R7: With `modeInterleave` low, beat k shows low bits equal to (start + k) mod 4.
- R8: With `modeInterleave` high, beat k shows low bits equal to start XOR k. For example, a start at 01 gives 01, 00, 11, 10.
- R9: In a cycle with no active strobe and `advanceN` high, `curAddr` is held (suspend).
- R10: The beat number wraps after the fourth beat. Further advances continue the wrapped sequence and never change `curAddr` above the two low bits.
- R11: `writeEff` is a registered copy of `writeReq`. It is forced low in the cycle after a processor-strobe start, and in that cycle `procFirst` is high. After a controller-strobe start, and on later beats, `writeEff` follows `writeReq` while the block is selected.
- R12: `advanceN` is ignored in a cycle with an active strobe. It is also ignored while the block is deselected, in which case `curAddr` is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| extAddr | input | ADDR_W | External address captured at burst start |
| procStrobeN | input | 1 | Processor address-status strobe, active low |
| ctrlStrobeN | input | 1 | Controller address-status strobe, active low |
| advanceN | input | 1 | Step to the next beat, active low |
| selN | input | 1 | Primary chip enable, active low |
| selHi | input | 1 | Secondary chip enable, active high |
| selLoN | input | 1 | Secondary chip enable, active low |
| modeInterleave | input | 1 | Burst order strap: 1 = interleaved, 0 = linear |
| writeReq | input | 1 | Write request, active high |
| curAddr | output | ADDR_W | Current internal address |
| selected | output | 1 | Block is selected |
| procFirst | output | 1 | First cycle of a processor-strobe burst |
| deselPulse | output | 1 | A deselect happened at the last edge |
| writeEff | output | 1 | Qualified write for the current cycle |

## Verification
The checker watches every cycle for these relations between strobes, enables and outputs:
- the load of `extAddr` on a qualified start;
- the drop of `selected` together with `deselPulse` on any unqualified strobe;
- `selected` held between strobes;
- the upper address bits frozen between strobes;
- the address held on a suspend or while deselected;
- the write mask whenever `procFirst` is high.

Only the directed scenarios can show the actual beat orders: the linear order from a start of 10, the interleaved order from 01, and the wrap into a fifth beat. They also show a processor strobe being ignored under a high primary enable while the advance still takes effect.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;

  // Command from control to datapath for one clock edge
  typedef struct packed {
    logic load;   // capture external address, clear beat number
    logic step;   // move to the next beat
  } seqCmd_t;

  // Secondary enables both in their active state
  function automatic logic secondaryOk(input logic hi, input logic loN);
    return hi & ~loN;
  endfunction

endpackage

// File: rtl/burst_seq_ctrl.sv
module burst_seq_ctrl
  import burst_seq_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    procStrobeN,
  input  logic    ctrlStrobeN,
  input  logic    advanceN,
  input  logic    selN,
  input  logic    selHi,
  input  logic    selLoN,
  input  logic    writeReq,
  output seqCmd_t cmd,
  output logic    selected,
  output logic    procFirst,
  output logic    deselPulse,
  output logic    writeEff
);

  logic procActive;
  logic ctrlActive;
  logic anyStrobe;
  logic fullSel;
  logic startBurst;
  logic dropSel;

  // the primary enable masks the processor strobe only
  assign procActive = ~procStrobeN & ~selN;
  assign ctrlActive = ~ctrlStrobeN;
  assign anyStrobe  = procActive | ctrlActive;
  assign fullSel    = ~selN & secondaryOk(selHi, selLoN);
  assign startBurst = anyStrobe & fullSel;
  assign dropSel    = anyStrobe & ~fullSel;

  always_comb begin
    cmd      = '0;
    cmd.load = startBurst;
    cmd.step = ~anyStrobe & ~advanceN & selected;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      selected   <= 1'b0;
      procFirst  <= 1'b0;
      deselPulse <= 1'b0;
      writeEff   <= 1'b0;
    end else if (startBurst) begin
      selected   <= 1'b1;
      procFirst  <= procActive;
      deselPulse <= 1'b0;
      writeEff   <= procActive ? 1'b0 : writeReq;
    end else if (dropSel) begin
      selected   <= 1'b0;
      procFirst  <= 1'b0;
      deselPulse <= 1'b1;
      writeEff   <= 1'b0;
    end else begin
      procFirst  <= 1'b0;
      deselPulse <= 1'b0;
      writeEff   <= selected & writeReq;
    end
  end

endmodule

// File: rtl/burst_seq_dp.sv
module burst_seq_dp
  import burst_seq_pkg::*;
#(
  parameter int ADDR_W = 17,
  parameter int BEAT_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqCmd_t           cmd,
  input  logic [ADDR_W-1:0] extAddr,
  input  logic              modeInterleave,
  output logic [ADDR_W-1:0] curAddr
);

  localparam int UPPER_W = ADDR_W - BEAT_W;

  logic [UPPER_W-1:0] upperQ;
  logic [BEAT_W-1:0]  startQ;
  logic [BEAT_W-1:0]  beatQ;
  logic [BEAT_W-1:0]  linBits;
  logic [BEAT_W-1:0]  ilvBits;
  logic [BEAT_W-1:0]  lowBits;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      upperQ <= '0;
      startQ <= '0;
      beatQ  <= '0;
    end else if (cmd.load) begin
      upperQ <= extAddr[ADDR_W-1:BEAT_W];
      startQ <= extAddr[BEAT_W-1:0];
      beatQ  <= '0;
    end else if (cmd.step) begin
      beatQ  <= beatQ + 1'b1;   // wraps modulo the burst length
    end
  end

  assign linBits = startQ + beatQ;

  genvar gi;
  generate
    for (gi = 0; gi < BEAT_W; gi++) begin : g_ilv
      assign ilvBits[gi] = startQ[gi] ^ beatQ[gi];
    end
  endgenerate

  assign lowBits = modeInterleave ? ilvBits : linBits;
  assign curAddr = {upperQ, lowBits};

endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
  import burst_seq_pkg::*;
#(
  parameter int ADDR_W = 17,
  parameter int BEAT_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] extAddr,
  input  logic              procStrobeN,
  input  logic              ctrlStrobeN,
  input  logic              advanceN,
  input  logic              selN,
  input  logic              selHi,
  input  logic              selLoN,
  input  logic              modeInterleave,
  input  logic              writeReq,
  output logic [ADDR_W-1:0] curAddr,
  output logic              selected,
  output logic              procFirst,
  output logic              deselPulse,
  output logic              writeEff
);

  seqCmd_t cmd;

  burst_seq_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .procStrobeN(procStrobeN),
    .ctrlStrobeN(ctrlStrobeN),
    .advanceN   (advanceN),
    .selN       (selN),
    .selHi      (selHi),
    .selLoN     (selLoN),
    .writeReq   (writeReq),
    .cmd        (cmd),
    .selected   (selected),
    .procFirst  (procFirst),
    .deselPulse (deselPulse),
    .writeEff   (writeEff)
  );

  burst_seq_dp #(.ADDR_W(ADDR_W), .BEAT_W(BEAT_W)) u_dp (
    .clk           (clk),
    .rstN          (rstN),
    .cmd           (cmd),
    .extAddr       (extAddr),
    .modeInterleave(modeInterleave),
    .curAddr       (curAddr)
  );

endmodule

// File: rtl/burst_addr_seq_chk.sv
module burst_addr_seq_chk #(
  parameter int ADDR_W = 17,
  parameter int BEAT_W = 2
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] extAddr,
  input logic              procStrobeN,
  input logic              ctrlStrobeN,
  input logic              advanceN,
  input logic              selN,
  input logic              selHi,
  input logic              selLoN,
  input logic              modeInterleave,
  input logic [ADDR_W-1:0] curAddr,
  input logic              selected,
  input logic              procFirst,
  input logic              deselPulse,
  input logic              writeEff
);

  logic noStrobe;
  logic fullSel;
  assign noStrobe = ctrlStrobeN & (procStrobeN | selN);
  assign fullSel  = ~selN & selHi & ~selLoN;

  // R2
  a_r2_load_ext: assert property (@(posedge clk) disable iff (!rstN)
    (!noStrobe && fullSel) |=> (curAddr == $past(extAddr)) && selected);

  // R4 and R5
  a_r5_drop_deselects: assert property (@(posedge clk) disable iff (!rstN)
    (!noStrobe && !fullSel) |=> !selected && deselPulse);

  // R6 and R3
  a_r6_sel_held: assert property (@(posedge clk) disable iff (!rstN)
    noStrobe |=> $stable(selected) && !deselPulse);

  // R9
  a_r9_suspend_hold: assert property (@(posedge clk) disable iff (!rstN)
    (noStrobe && advanceN) |=>
      ($stable(curAddr) || (modeInterleave != $past(modeInterleave))));

  // R10
  a_r10_upper_fixed: assert property (@(posedge clk) disable iff (!rstN)
    noStrobe |=> $stable(curAddr[ADDR_W-1:BEAT_W]));

  // R11
  a_r11_first_read: assert property (@(posedge clk) disable iff (!rstN)
    procFirst |-> !writeEff);

  // R12
  a_r12_idle_when_off: assert property (@(posedge clk) disable iff (!rstN)
    (noStrobe && !selected) |=>
      ($stable(curAddr) || (modeInterleave != $past(modeInterleave))));

endmodule

bind burst_addr_seq burst_addr_seq_chk #(.ADDR_W(ADDR_W), .BEAT_W(BEAT_W)) u_chk (
  .clk           (clk),
  .rstN          (rstN),
  .extAddr       (extAddr),
  .procStrobeN   (procStrobeN),
  .ctrlStrobeN   (ctrlStrobeN),
  .advanceN      (advanceN),
  .selN          (selN),
  .selHi         (selHi),
  .selLoN        (selLoN),
  .modeInterleave(modeInterleave),
  .curAddr       (curAddr),
  .selected      (selected),
  .procFirst     (procFirst),
  .deselPulse    (deselPulse),
  .writeEff      (writeEff)
);

// File: tb/burst_addr_seq_bench.sv
module burst_addr_seq_bench;

  localparam int ADDR_W = 17;
  localparam int BEAT_W = 2;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic [ADDR_W-1:0] extAddr = '0;
  logic              procStrobeN = 1'b1;
  logic              ctrlStrobeN = 1'b1;
  logic              advanceN = 1'b1;
  logic              selN = 1'b0;
  logic              selHi = 1'b1;
  logic              selLoN = 1'b0;
  logic              modeInterleave = 1'b0;
  logic              writeReq = 1'b0;
  logic [ADDR_W-1:0] curAddr;
  logic              selected;
  logic              procFirst;
  logic              deselPulse;
  logic              writeEff;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  burst_addr_seq #(.ADDR_W(ADDR_W), .BEAT_W(BEAT_W)) u_burst_addr_seq (
    .clk(clk), .rstN(rstN), .extAddr(extAddr), .procStrobeN(procStrobeN),
    .ctrlStrobeN(ctrlStrobeN), .advanceN(advanceN), .selN(selN), .selHi(selHi),
    .selLoN(selLoN), .modeInterleave(modeInterleave), .writeReq(writeReq),
    .curAddr(curAddr), .selected(selected), .procFirst(procFirst),
    .deselPulse(deselPulse), .writeEff(writeEff)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // one clock edge; inputs change and outputs are sampled 1 ns after it
  task automatic cyc();
    @(posedge clk);
    #1;
  endtask

  task automatic idle();
    procStrobeN = 1'b1; ctrlStrobeN = 1'b1; advanceN = 1'b1;
    selN = 1'b0; selHi = 1'b1; selLoN = 1'b0;
  endtask

  task automatic ctrlLoad(input logic [ADDR_W-1:0] a);
    idle(); extAddr = a; ctrlStrobeN = 1'b0;
    cyc();
    idle();
  endtask

  task automatic t_reset();
    chk("R1 addr", 32'(curAddr), 0);
    chk("R1 sel", 32'(selected), 0);
    chk("R1 first", 32'(procFirst), 0);
    chk("R1 desel", 32'(deselPulse), 0);
    chk("R1 wr", 32'(writeEff), 0);
  endtask

  task automatic t_linear();
    logic [ADDR_W-1:0] a = 17'h0A5C6;
    modeInterleave = 1'b0; writeReq = 1'b1;
    ctrlLoad(a);
    chk("R2 load addr", 32'(curAddr), 32'(a));
    chk("R2 selected", 32'(selected), 1);
    chk("R11 ctrl first wr", 32'(writeEff), 1);
    chk("R11 ctrl first flag", 32'(procFirst), 0);
    for (int k = 1; k <= 5; k++) begin
      advanceN = 1'b0;
      cyc();
      chk("R7 R10 linear beat", 32'(curAddr), 32'({a[ADDR_W-1:2], 2'((2 + k) % 4)}));
    end
    idle();
  endtask

  task automatic t_interleave();
    logic [ADDR_W-1:0] b = 17'h13579;
    modeInterleave = 1'b1; writeReq = 1'b1;
    idle(); extAddr = b; procStrobeN = 1'b0;
    cyc();
    idle();
    chk("R2 proc load", 32'(curAddr), 32'(b));
    chk("R11 proc flag", 32'(procFirst), 1);
    chk("R11 proc wr masked", 32'(writeEff), 0);
    for (int k = 1; k <= 4; k++) begin
      advanceN = 1'b0;
      cyc();
      chk("R8 R10 interleave beat", 32'(curAddr),
          32'({b[ADDR_W-1:2], 2'b01 ^ 2'(k % 4)}));
      chk("R11 later wr", 32'(writeEff), 1);
      chk("R11 flag gone", 32'(procFirst), 0);
    end
    idle();
  endtask

  task automatic t_suspend();
    logic [ADDR_W-1:0] b = 17'h13579;
    idle();
    for (int k = 0; k < 2; k++) begin
      cyc();
      chk("R9 suspend", 32'(curAddr), 32'(b));
    end
    advanceN = 1'b0;
    cyc();
    chk("R9 resume", 32'(curAddr), 32'({b[ADDR_W-1:2], 2'b00}));
    idle();
  endtask

  task automatic t_procBlocked();
    logic [ADDR_W-1:0] b = 17'h13579;
    idle(); selN = 1'b1; procStrobeN = 1'b0; extAddr = 17'h00003; advanceN = 1'b0;
    cyc();
    chk("R3 no load, advance", 32'(curAddr), 32'({b[ADDR_W-1:2], 2'b11}));
    chk("R3 still selected", 32'(selected), 1);
    chk("R3 no desel", 32'(deselPulse), 0);
    idle();
  endtask

  task automatic t_advOnStrobe();
    modeInterleave = 1'b0;
    idle(); extAddr = 17'h1FFFF; ctrlStrobeN = 1'b0; advanceN = 1'b0;
    cyc();
    chk("R12 strobe beats advance", 32'(curAddr), 32'h1FFFF);
    ctrlStrobeN = 1'b1;
    cyc();
    chk("R10 upper unchanged on wrap", 32'(curAddr), 32'h1FFFC);
    idle();
  endtask

  task automatic t_ctrlDesel();
    writeReq = 1'b1;
    idle(); selN = 1'b1; ctrlStrobeN = 1'b0; extAddr = '0;
    cyc();
    chk("R4 sel cleared", 32'(selected), 0);
    chk("R4 desel pulse", 32'(deselPulse), 1);
    chk("R4 addr held", 32'(curAddr), 32'h1FFFC);
    chk("R4 no write", 32'(writeEff), 0);
    idle(); advanceN = 1'b0;
    cyc();
    chk("R12 no step while off", 32'(curAddr), 32'h1FFFC);
    chk("R4 pulse ends", 32'(deselPulse), 0);
    chk("R12 still off", 32'(selected), 0);
    chk("R12 no write while off", 32'(writeEff), 0);
    idle();
  endtask

  task automatic t_secDesel();
    ctrlLoad(17'h04000);
    chk("R2 reselect", 32'(selected), 1);
    idle(); procStrobeN = 1'b0; selHi = 1'b0;
    cyc();
    chk("R5 proc hi-enable off", 32'(selected), 0);
    chk("R5 proc pulse", 32'(deselPulse), 1);
    idle();
    ctrlLoad(17'h04000);
    idle(); ctrlStrobeN = 1'b0; selLoN = 1'b1;
    cyc();
    chk("R5 ctrl lo-enable off", 32'(selected), 0);
    chk("R5 ctrl pulse", 32'(deselPulse), 1);
    idle();
  endtask

  task automatic t_secIgnored();
    ctrlLoad(17'h04000);
    idle(); selHi = 1'b0; selLoN = 1'b1;
    cyc();
    chk("R6 sel held", 32'(selected), 1);
    chk("R6 no pulse", 32'(deselPulse), 0);
    chk("R6 addr held", 32'(curAddr), 32'h04000);
    idle();
  endtask

  initial begin
    #2000000;
    if (!finished) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    t_reset();
    rstN = 1'b1;
    cyc();
    t_linear();
    t_interleave();
    t_suspend();
    t_procBlocked();
    t_advOnStrobe();
    t_ctrlDesel();
    t_secDesel();
    t_secIgnored();
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule